// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides, for every completed CAN frame, whether the frame is kept and which of two receive queues it goes to. It holds a configurable set of filter banks, 14 by default. Each bank has two 32-bit pattern registers and four control bits. The control bits set whether the bank is enabled, whether it compares exact identifiers (list) or an identifier under a bit mask (mask), whether it works as one 32-bit filter or as 16-bit half filters, and which queue it feeds.

Configuration is written through a small write port. A write lands only while the global configuration-window input is high, so a running filter set cannot be altered by a stray write. The receive side presents the identifier fields of each finished frame with a one-cycle valid strobe. One cycle later the block reports accept, the target queue, and the bank and slot that matched. When several filters match, the one with the lowest number wins.

Top module: `can_accept_filter`

## Requirements
- R1: In 32-bit mask scale, pattern register A holds the identifier word and register B the mask; a frame matches when every bit set in B equals the same bit of the frame word, and bits clear in B are ignored (ID 0x102 with mask 0x7FF takes only 0x102; with mask 0x7FE it takes 0x102 and 0x103). The match is reported as slot 0.
- R2: In 32-bit list scale, registers A and B each hold one exact frame word; a match on A reports slot 0 and a match on B reports slot 1.
- R3: In 16-bit list scale, a bank holds four exact 16-bit words: A[15:0] is slot 0, A[31:16] slot 1, B[15:0] slot 2, B[31:16] slot 3.
- R4: In 16-bit mask scale, A[15:0] with mask B[15:0] is slot 0, and A[31:16] with mask B[31:16] is slot 1.
- R5: The 32-bit frame word is {std_id[10:0], ext_id[17:0], ide, rtr, 1'b0}. The 16-bit frame word is {std_id[10:0], rtr, ide, ext_id[17:15]}.
- R6: A write with cfg_sel 0 loads register A of bank cfg_bank, cfg_sel 1 loads register B, and cfg_sel 2 loads the control bits from cfg_wdata[3:0]: bit 0 enable, bit 1 list (1) or mask (0), bit 2 scale 32-bit (1) or 16-bit (0), bit 3 queue 1 (1) or queue 0 (0). cfg_sel 3 and bank numbers past the last bank are ignored.
- R7: A disabled bank never matches. A frame with no match gives flt_accept low with flt_bank and flt_slot zero.
- R8: Among matching filters, the lowest bank wins, and within it the lowest slot wins. flt_fifo is the queue bit of the winning bank.
- R9: Writes change no configuration while cfg_init is low.
- R10: flt_valid is high exactly in the cycle after a cycle with frm_valid high. After reset all outputs are zero and every bank is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_init | input | 1 | Configuration window; writes land only while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | BANK_W (4) | Bank addressed by the write |
| cfg_sel | input | 2 | 0 register A, 1 register B, 2 control bits |
| cfg_wdata | input | 32 | Write data |
| frm_valid | input | 1 | Frame identifier fields are valid this cycle |
| frm_std_id | input | 11 | Standard identifier |
| frm_ext_id | input | 18 | Extended identifier bits |
| frm_ide | input | 1 | Extended-format flag |
| frm_rtr | input | 1 | Remote-request flag |
| flt_valid | output | 1 | Decision strobe, one cycle after frm_valid |
| flt_accept | output | 1 | Frame matched an enabled filter |
| flt_fifo | output | 1 | Target queue of the winning bank |
| flt_bank | output | BANK_W (4) | Winning bank |
| flt_slot | output | 2 | Winning filter slot inside the bank |

## Verification
The bench aims at the places where the four scale and mode combinations are easy to get wrong. A swapped half order in 16-bit scale reports the wrong slot, for example 0x301 as slot 0. If the IDE or RTR bit sits in the wrong place, a remote or extended frame passes a filter set up for data or standard frames. If the mask sense is inverted, 0x103 gets through the exact filter. It checks priority by making two banks claim 0x102 and then disabling the lower one, which catches a picker that favours the highest index. It also tries writes with the configuration window closed, both to enable a match-all bank and to clear a mask. A design that ignored the window would then accept 0x7AB, or route 0x103 through bank 0.

// File: rtl/acf_pkg.sv
// Shared types and widths for the CAN acceptance filter.
// Assumes a 29-bit identifier split as 11 standard plus 18 extension bits.
package acf_pkg;
    localparam int STD_W   = 11;
    localparam int EXT_W   = 18;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int SLOTS   = 4;

    // Per-bank control bits, packed in write-data order [3:0].
    typedef struct packed {
        logic to_q1;    // bit 3: route to queue 1
        logic wide;     // bit 2: one 32-bit filter
        logic list;     // bit 1: exact list instead of id/mask
        logic enable;   // bit 0: bank takes part in matching
    } bank_ctl_t;

    typedef enum logic [1:0] {
        SEL_REG_A = 2'd0,
        SEL_REG_B = 2'd1,
        SEL_CTL   = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/acf_cfg_store.sv
// Configuration storage for all filter banks.
// Writes take effect only while cfg_init is high; out-of-range banks and
// selector 3 are dropped. Resets every bank to disabled with zero patterns.
module acf_cfg_store
    import acf_pkg::*;
#(
    parameter int NUM_BANKS = 14,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_init,
    input  logic                              cfg_we,
    input  logic [BANK_W-1:0]                 cfg_bank,
    input  logic [1:0]                        cfg_sel,
    input  logic [WORD_W-1:0]                 cfg_wdata,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]  reg_a,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]  reg_b,
    output bank_ctl_t [NUM_BANKS-1:0]         ctl
);
    logic wr_ok;

    // Gate the write strobe with the configuration window and range.
    always_comb begin
        wr_ok = cfg_we && cfg_init && (int'(cfg_bank) < NUM_BANKS);
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            // Load this bank's registers on an accepted write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    reg_a[g] <= '0;
                    reg_b[g] <= '0;
                    ctl[g]   <= '0;
                end else if (wr_ok && (int'(cfg_bank) == g)) begin
                    case (cfg_sel_e'(cfg_sel))
                        SEL_REG_A: reg_a[g] <= cfg_wdata;
                        SEL_REG_B: reg_b[g] <= cfg_wdata;
                        SEL_CTL:   ctl[g]   <= bank_ctl_t'(cfg_wdata[3:0]);
                        default:   ;
                    endcase
                end
            end
        end
    endgenerate

    // R9: with the window closed nothing in the store may move.
    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_init |=> ($stable(reg_a) && $stable(reg_b) && $stable(ctl)));
endmodule

// File: rtl/acf_bank_match.sv
// Combinational match of one bank against the frame words.
// Produces one hit bit per slot; slots unused by the bank's mode stay low,
// and a disabled bank reports no hits.
module acf_bank_match
    import acf_pkg::*;
(
    input  logic [WORD_W-1:0] reg_a,
    input  logic [WORD_W-1:0] reg_b,
    input  bank_ctl_t         ctl,
    input  logic [WORD_W-1:0] word32,
    input  logic [HALF_W-1:0] word16,
    output logic [SLOTS-1:0]  slot_hit
);
    logic [SLOTS-1:0] list32, mask32, list16, mask16, raw;

    // Evaluate every mode in parallel; the control bits pick one.
    always_comb begin
        list32 = {2'b00, word32 == reg_b, word32 == reg_a};
        mask32 = {3'b000, ((word32 ^ reg_a) & reg_b) == '0};
        list16 = {word16 == reg_b[31:16], word16 == reg_b[15:0],
                  word16 == reg_a[31:16], word16 == reg_a[15:0]};
        mask16 = {2'b00,
                  ((word16 ^ reg_a[31:16]) & reg_b[31:16]) == '0,
                  ((word16 ^ reg_a[15:0])  & reg_b[15:0])  == '0};
        case ({ctl.wide, ctl.list})
            2'b11:   raw = list32;
            2'b10:   raw = mask32;
            2'b01:   raw = list16;
            default: raw = mask16;
        endcase
        slot_hit = ctl.enable ? raw : '0;
    end
endmodule

// File: rtl/acf_pick_first.sv
// Priority picker: returns the lowest set index of the hit vector.
// Index = bank * 4 + slot, so lower banks win, then lower slots.
module acf_pick_first #(
    parameter int N     = 56,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the last assignment is the lowest hit.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
// CAN receive acceptance filter top.
// Builds the 32- and 16-bit frame words, matches them in every bank,
// picks the lowest matching filter and registers the decision one cycle
// after frm_valid. Assumes frame fields are stable while frm_valid is high.
module can_accept_filter
    import acf_pkg::*;
#(
    parameter int NUM_BANKS = 14,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_init,
    input  logic              cfg_we,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              frm_valid,
    input  logic [10:0]       frm_std_id,
    input  logic [17:0]       frm_ext_id,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    output logic              flt_valid,
    output logic              flt_accept,
    output logic              flt_fifo,
    output logic [BANK_W-1:0] flt_bank,
    output logic [1:0]        flt_slot
);
    localparam int NSLOT = NUM_BANKS * SLOTS;
    localparam int SEL_W = BANK_W + 2;

    logic [NUM_BANKS-1:0][WORD_W-1:0] reg_a, reg_b;
    bank_ctl_t [NUM_BANKS-1:0]        ctl;
    logic [WORD_W-1:0]                word32;
    logic [HALF_W-1:0]                word16;
    logic [NSLOT-1:0]                 hits;
    logic                             pick_any;
    logic [SEL_W-1:0]                 pick_idx;
    logic [BANK_W-1:0]                pick_bank;
    logic [NSLOT-1:0]                 below_pick;

    acf_cfg_store #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_we(cfg_we),
        .cfg_bank(cfg_bank), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .reg_a(reg_a), .reg_b(reg_b), .ctl(ctl)
    );

    // Assemble the comparison words from the frame fields.
    always_comb begin
        word32 = {frm_std_id, frm_ext_id, frm_ide, frm_rtr, 1'b0};
        word16 = {frm_std_id, frm_rtr, frm_ide, frm_ext_id[17:15]};
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
            acf_bank_match u_match (
                .reg_a(reg_a[b]), .reg_b(reg_b[b]), .ctl(ctl[b]),
                .word32(word32), .word16(word16),
                .slot_hit(hits[b*SLOTS +: SLOTS])
            );
        end
    endgenerate

    acf_pick_first #(.N(NSLOT), .IDX_W(SEL_W)) u_pick (
        .hits(hits), .any(pick_any), .idx(pick_idx)
    );

    // Split the flat winner index into bank and mask of lower slots.
    always_comb begin
        pick_bank  = pick_idx[SEL_W-1:2];
        below_pick = (NSLOT'(1) << pick_idx) - NSLOT'(1);
    end

    // Register the decision for the frame presented last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_valid  <= 1'b0;
            flt_accept <= 1'b0;
            flt_fifo   <= 1'b0;
            flt_bank   <= '0;
            flt_slot   <= '0;
        end else begin
            flt_valid  <= frm_valid;
            flt_accept <= frm_valid && pick_any;
            if (frm_valid) begin
                flt_fifo <= pick_any && ctl[pick_bank].to_q1;
                flt_bank <= pick_bank;
                flt_slot <= pick_idx[1:0];
            end
        end
    end

    // R8: the picked slot must be a real hit.
    a_r8_pick_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> hits[pick_idx]);
    // R8: no filter numbered below the winner may match.
    a_r8_none_lower: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> ((hits & below_pick) == '0));
    // R7: a rejected frame reports bank and slot zero.
    a_r7_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_accept) |-> (flt_bank == '0 && flt_slot == '0 && !flt_fifo));
    // R10: a frame strobe produces a decision strobe next cycle.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> flt_valid);
    // R10: no decision strobe without a frame.
    a_r10_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !flt_valid);
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_init = 1'b0, cfg_we = 1'b0;
    logic [3:0]  cfg_bank = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frm_valid = 1'b0;
    logic [10:0] frm_std_id = '0;
    logic [17:0] frm_ext_id = '0;
    logic        frm_ide = 1'b0, frm_rtr = 1'b0;
    logic        flt_valid, flt_accept, flt_fifo;
    logic [3:0]  flt_bank;
    logic [1:0]  flt_slot;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_accept_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_we(cfg_we),
        .cfg_bank(cfg_bank), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .frm_valid(frm_valid), .frm_std_id(frm_std_id), .frm_ext_id(frm_ext_id),
        .frm_ide(frm_ide), .frm_rtr(frm_rtr),
        .flt_valid(flt_valid), .flt_accept(flt_accept), .flt_fifo(flt_fifo),
        .flt_bank(flt_bank), .flt_slot(flt_slot)
    );

    // Frame words as stated in R5.
    function automatic logic [31:0] w32(logic [10:0] s, logic [17:0] e, logic i, logic r);
        return {s, e, i, r, 1'b0};
    endfunction
    function automatic logic [15:0] w16(logic [10:0] s, logic [17:0] e, logic i, logic r);
        return {s, r, i, e[17:15]};
    endfunction

    // Vector: {std, ext, ide, rtr, accept, fifo, bank, slot}
    localparam logic [NV-1:0][38:0] VEC = '{
        {11'h102, 18'h0,     1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  2'd0},  // R1 exact + R8 lower bank wins
        {11'h103, 18'h0,     1'b0, 1'b0, 1'b1, 1'b1, 4'd1,  2'd0},  // R1 don't-care bit
        {11'h104, 18'h0,     1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0},  // R7 no match
        {11'h155, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2,  2'd0},  // R2 extended slot 0
        {11'h155, 18'h2AAAB, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0},  // R2 one ext bit off
        {11'h200, 18'h0,     1'b0, 1'b1, 1'b1, 1'b0, 4'd2,  2'd1},  // R2 slot 1, remote
        {11'h200, 18'h0,     1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0},  // R5 rtr compared
        {11'h300, 18'h0,     1'b0, 1'b0, 1'b1, 1'b1, 4'd3,  2'd0},  // R3 slot 0
        {11'h301, 18'h0,     1'b0, 1'b0, 1'b1, 1'b1, 4'd3,  2'd1},  // R3 slot 1
        {11'h302, 18'h0,     1'b0, 1'b1, 1'b1, 1'b1, 4'd3,  2'd2},  // R3 slot 2
        {11'h303, 18'h0,     1'b0, 1'b0, 1'b1, 1'b1, 4'd3,  2'd3},  // R3 slot 3
        {11'h302, 18'h0,     1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0},  // R5 16-bit rtr
        {11'h40A, 18'h0,     1'b0, 1'b0, 1'b1, 1'b0, 4'd4,  2'd0},  // R4 lower pair
        {11'h410, 18'h0,     1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0},  // R4 masked bit differs
        {11'h5C3, 18'h0,     1'b0, 1'b0, 1'b1, 1'b0, 4'd4,  2'd1},  // R4 upper pair
        {11'h40A, 18'h0,     1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0},  // R5 16-bit ide
        {11'h7FF, 18'h0,     1'b0, 1'b0, 1'b1, 1'b1, 4'd13, 2'd0},  // R6 last bank
        {11'h102, 18'h0,     1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0}   // R5 32-bit ide
    };

    task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int bank, int sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 4'(bank); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one frame and compare the decision one cycle later.
    task automatic frame(logic [10:0] s, logic [17:0] e, logic i, logic r,
                         logic acc, logic q, logic [3:0] bk, logic [1:0] sl, string tag);
        logic [7:0] act, exp;
        @(negedge clk);
        frm_valid = 1'b1; frm_std_id = s; frm_ext_id = e; frm_ide = i; frm_rtr = r;
        @(negedge clk);
        frm_valid = 1'b0;
        act = {flt_valid, flt_accept, flt_fifo, flt_bank, flt_slot[0]};
        exp = {1'b1, acc, q, bk, sl[0]};
        check(act == exp && flt_slot == sl, tag, {act[7:1], flt_slot[1]}, {exp[7:1], sl[1]});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: reset state.
        check({flt_valid, flt_accept, flt_fifo, flt_bank, flt_slot} == '0, "R10 reset",
              {flt_valid, flt_accept, flt_fifo, flt_bank, flt_slot[0]}, 8'h00);
        rst_n = 1'b1;
        // R10: an unconfigured block rejects everything (all banks disabled).
        frame(11'h102, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R10 disabled after reset");

        cfg_init = 1'b1;
        // R6 control bits: [0] enable, [1] list, [2] 32-bit, [3] queue 1.
        wr(0, 0, w32(11'h102, 0, 0, 0)); wr(0, 1, w32(11'h7FF, 0, 1, 0)); wr(0, 2, 32'h5);
        wr(1, 0, w32(11'h102, 0, 0, 0)); wr(1, 1, w32(11'h7FE, 0, 1, 0)); wr(1, 2, 32'hD);
        wr(2, 0, w32(11'h155, 18'h2AAAA, 1, 0)); wr(2, 1, w32(11'h200, 0, 0, 1)); wr(2, 2, 32'h7);
        wr(3, 0, {w16(11'h301, 0, 0, 0), w16(11'h300, 0, 0, 0)});
        wr(3, 1, {w16(11'h303, 0, 0, 0), w16(11'h302, 0, 0, 1)}); wr(3, 2, 32'hB);
        wr(4, 0, {w16(11'h500, 0, 0, 0), w16(11'h400, 0, 0, 0)});
        wr(4, 1, {w16(11'h700, 0, 1, 0), w16(11'h7F0, 0, 1, 0)}); wr(4, 2, 32'h1);
        wr(5, 0, 32'h0); wr(5, 1, 32'h0); wr(5, 2, 32'h4);
        wr(13, 0, w32(11'h7FF, 0, 0, 0)); wr(13, 1, w32(11'h7FE, 0, 0, 0)); wr(13, 2, 32'hF);
        wr(14, 2, 32'hF);   // R6 out-of-range bank dropped
        cfg_init = 1'b0;

        // R1/R2/R3/R4/R5/R7/R8 table walk.
        for (int v = 0; v < NV; v++) begin
            logic [38:0] t;
            t = VEC[NV-1-v];
            frame(t[38:28], t[27:10], t[9], t[8], t[7], t[6], t[5:2], t[1:0],
                  $sformatf("R1/R2/R3/R4/R5/R8 vector %0d", v));
        end

        // R10: strobe drops when no frame.
        @(negedge clk);
        check(!flt_valid, "R10 valid pulse", {7'd0, flt_valid}, 8'd0);

        // R9: writes with window closed are ignored.
        wr(5, 2, 32'h5);
        wr(0, 1, 32'h0);
        frame(11'h7AB, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, "R9 enable locked");
        frame(11'h103, 18'h0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 2'd0, "R9 mask locked");

        // R7/R8: enabling a match-all bank routes to its queue.
        cfg_init = 1'b1;
        wr(5, 2, 32'hD);
        wr(5, 3, 32'hFFFF_FFFF);   // R6 selector 3 dropped
        cfg_init = 1'b0;
        frame(11'h7AB, 18'h0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5, 2'd0, "R7 match-all bank");
        frame(11'h102, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 2'd0, "R8 bank0 before bank1");

        // R7/R8: disabling bank 0 hands 0x102 to bank 1.
        cfg_init = 1'b1;
        wr(0, 2, 32'h4);
        cfg_init = 1'b0;
        frame(11'h102, 18'h0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 2'd0, "R7 disabled bank skipped");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule